// File: doc/BRIEF.md
# Page-Chunked Flash Write Sequencer

This block turns one write request into a run of fixed-size page-program operations toward a flash array. A request gives a destination address, a source address and a length in bytes. The block reads source bytes from a byte-wide data port. It drives one programming pulse per byte into the array port, and steps both addresses forward one page at a time until the whole length has been written.

The target area is assumed to be erased already. Each page is always processed in full. Positions past the end of the request count as erased-value bytes (all ones). A byte equal to the erased value gets no pulse and costs a single cycle, so the time a page takes depends on its data. A destination that does not sit on a page boundary is refused with an error flag, and nothing is programmed.

Top module: `flash_page_writer`

## Requirements
- R1: Each accepted request is processed as ceil(len/128) pages of exactly 128 byte positions. Byte position i (counted from 0 across the request) programs destination address dst+i with the source byte at src+i, so both addresses advance by 128 from one page to the next.
- R2: Byte positions at or beyond the requested length in the last page are treated as filler with value 8'hFF. They are never pulsed.
- R3: A byte of value 8'hFF (data or filler) takes one cycle with `fl_prog` low. Any other byte holds `fl_prog` high for exactly PULSE_CYC cycles, with `fl_addr` and `fl_data` stable. `fl_data` is never 8'hFF while `fl_prog` is high.
- R4: A request whose destination has a nonzero value in bits [6:0] raises `err` for one cycle, in the cycle after the request. It raises neither `busy` nor `done`, and it programs nothing.
- R5: `busy` rises in the cycle after an accepted request and stays high for exactly the sum of the per-byte costs of all pages. `done` is then high for one cycle with `busy` low.
- R6: A request is taken only while `busy` and `done` are both low. A request seen while busy is ignored and causes no programming.
- R7: An aligned request of length 0 programs nothing and raises `done` in the cycle after the request, without `busy`.
- R8: After reset, `busy`, `done`, `err` and `fl_prog` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_dst | input | ADDR_W | Destination start address in the array |
| req_src | input | ADDR_W | Source start address |
| req_len | input | LEN_W | Length in bytes |
| src_rd | output | 1 | Source read strobe (byte inside the requested length) |
| src_addr | output | ADDR_W | Source byte address |
| src_data | input | 8 | Source byte, valid in the same cycle as `src_addr` |
| fl_prog | output | 1 | Programming pulse active |
| fl_addr | output | ADDR_W | Array byte address under program |
| fl_data | output | 8 | Byte value being programmed |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle alignment error pulse |

## Verification
The bench looks at a length that ends partway into its last page. A design that padded with data or zeros would pulse bytes past the end, and these show up as unexpected scoreboard entries. Pages made of all-ones data, or mixed with 0xFF bytes, check that the busy time is exactly one cycle per skipped byte. A design that pulsed erased bytes would stretch that time and would drive 8'hFF on the array port. The bench also uses a multi-page run to catch address steps that are wrong between pages, a misaligned start to catch a design that programs anyway, a zero length, and a request injected while busy that a faulty design would start on.

// File: rtl/fws_pkg.sv
package fws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BYTE  = 2'd1,
        ST_PULSE = 2'd2,
        ST_FIN   = 2'd3
    } fws_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/fws_byte_pick.sv
module fws_byte_pick #(
    parameter int IDX_W = 7,
    parameter int LEN_W = 12
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [LEN_W-1:0] left,
    input  logic [7:0]       src_data,
    output logic             in_range,
    output logic [7:0]       byte_val,
    output logic             skip
);
    import fws_pkg::*;

    always_comb begin
        in_range = LEN_W'(idx) < left;
        byte_val = in_range ? src_data : ERASED_BYTE;
        skip     = (byte_val == ERASED_BYTE);
    end
endmodule

// File: rtl/fws_pulse_timer.sv
module fws_pulse_timer #(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last
);
    localparam int CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CW'(PULSE_CYC - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        last = (cnt_q == CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 128,
    parameter int PULSE_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_dst,
    input  logic [ADDR_W-1:0] req_src,
    input  logic [LEN_W-1:0]  req_len,
    output logic              src_rd,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [7:0]        src_data,
    output logic              fl_prog,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_data,
    output logic              busy,
    output logic              done,
    output logic              err
);
    import fws_pkg::*;

    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);
    localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] PAGE_STEP = ADDR_W'(PAGE_BYTES);

    typedef struct packed {
        fws_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  left;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic [7:0]        data;
        logic              err;
    } regs_t;

    regs_t d, q;

    logic       in_range, skip, advance, tmr_load, tmr_last;
    logic [7:0] byte_val;

    fws_byte_pick #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_pick (
        .idx      (q.idx),
        .left     (q.left),
        .src_data (src_data),
        .in_range (in_range),
        .byte_val (byte_val),
        .skip     (skip)
    );

    fws_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .last  (tmr_last)
    );

    always_comb begin
        d        = q;
        d.err    = 1'b0;
        advance  = 1'b0;
        tmr_load = 1'b0;
        fl_prog  = 1'b0;
        fl_data  = q.data;
        fl_addr  = q.dst + ADDR_W'(q.idx);
        src_addr = q.src + ADDR_W'(q.idx);
        src_rd   = (q.st == ST_BYTE) && in_range;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_dst[IDX_W-1:0] != '0) begin
                        d.err = 1'b1;
                    end else begin
                        d.dst  = req_dst;
                        d.src  = req_src;
                        d.left = req_len;
                        d.idx  = '0;
                        d.st   = (req_len == '0) ? ST_FIN : ST_BYTE;
                    end
                end
            end
            ST_BYTE: begin
                if (skip) begin
                    advance = 1'b1;
                end else begin
                    fl_prog = 1'b1;
                    fl_data = byte_val;
                    d.data  = byte_val;
                    if (PULSE_CYC == 1) begin
                        advance = 1'b1;
                    end else begin
                        tmr_load = 1'b1;
                        d.st     = ST_PULSE;
                    end
                end
            end
            ST_PULSE: begin
                fl_prog = 1'b1;
                if (tmr_last) advance = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase

        if (advance) begin
            if (q.idx == LAST_IDX) begin
                d.idx = '0;
                if (q.left <= PAGE_LEN) begin
                    d.st = ST_FIN;
                end else begin
                    d.left = q.left - PAGE_LEN;
                    d.dst  = q.dst + PAGE_STEP;
                    d.src  = q.src + PAGE_STEP;
                    d.st   = ST_BYTE;
                end
            end else begin
                d.idx = q.idx + 1'b1;
                d.st  = ST_BYTE;
            end
        end

        busy = (q.st == ST_BYTE) || (q.st == ST_PULSE);
        done = (q.st == ST_FIN);
        err  = q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.idx  <= '0;
            q.left <= '0;
            q.dst  <= '0;
            q.src  <= '0;
            q.data <= '0;
            q.err  <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              fl_prog,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_data,
    input logic              busy,
    input logic              done,
    input logic              err
);
    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    no_ff_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_prog |-> fl_data != 8'hFF);

    // R5
    prog_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_prog |-> busy);

    // R4
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !done && !fl_prog);

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R4
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
endmodule

bind flash_page_writer fws_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .fl_prog   (fl_prog),
    .fl_addr   (fl_addr),
    .fl_data   (fl_data),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/flash_page_writer_test.sv
module flash_page_writer_test;
    localparam int AW = 16;
    localparam int LW = 12;
    localparam int P  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_dst = '0, req_src = '0;
    logic [LW-1:0] req_len = '0;
    logic          src_rd, fl_prog, busy, done, err;
    logic [AW-1:0] src_addr, fl_addr;
    logic [7:0]    src_data, fl_data;

    logic [7:0] src_mem   [0:4095];
    logic [7:0] flash_mem [0:4095];

    int checks = 0;
    int fails  = 0;
    logic [23:0] exp_q[$];

    always #5 clk = ~clk;

    assign src_data = src_mem[src_addr[11:0]];

    flash_page_writer #(.ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(128), .PULSE_CYC(P)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
        .req_src(req_src), .req_len(req_len), .src_rd(src_rd), .src_addr(src_addr),
        .src_data(src_data), .fl_prog(fl_prog), .fl_addr(fl_addr), .fl_data(fl_data),
        .busy(busy), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: detect each pulse, pop scoreboard, check pulse length (R1, R3)
    logic          prev_prog = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    int            run_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (fl_prog && (!prev_prog || fl_addr != prev_addr)) begin
                if (prev_prog) check(run_len == P, "R3 pulse length", run_len, P);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1/R2/R6 unexpected pulse", int'({fl_addr, fl_data}), 0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check({fl_addr, fl_data} == e, "R1 pulse addr/data", int'({fl_addr, fl_data}), int'(e));
                end
                run_len = 1;
            end else if (fl_prog) begin
                run_len++;
                check(fl_addr == prev_addr, "R3 stable address", fl_addr, prev_addr);
            end else if (prev_prog) begin
                check(run_len == P, "R3 pulse length", run_len, P);
            end
            if (fl_prog) flash_mem[fl_addr[11:0]] = fl_data;
            prev_prog = fl_prog;
            prev_addr = fl_addr;
        end
    end

    // Driver: push expected pulses, issue request, measure busy time
    task automatic run_req(input logic [AW-1:0] dst, input logic [AW-1:0] src,
                           input int len, input bit inject);
        int pages, cost, busy_cyc, t;
        bit misal;
        misal = (dst[6:0] != 0);
        pages = (len + 127) / 128;
        cost = 0;
        if (!misal) begin
            for (int i = 0; i < pages * 128; i++) begin
                logic [7:0] b;
                b = (i < len) ? src_mem[(src + i) & 12'hFFF] : 8'hFF;
                if (b == 8'hFF) cost += 1;
                else begin
                    cost += P;
                    exp_q.push_back({dst + AW'(i), b});
                end
            end
        end
        @(negedge clk);
        req_dst = dst; req_src = src; req_len = LW'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (misal) begin
            check(err == 1'b1, "R4 err pulse", err, 1);
            check(busy == 1'b0 && done == 1'b0, "R4 no busy/done", {busy, done}, 0);
            @(negedge clk);
            check(err == 1'b0, "R4 err one cycle", err, 0);
            return;
        end
        if (len == 0) begin
            check(done == 1'b1 && busy == 1'b0, "R7 zero length done", {busy, done}, 1);
        end
        busy_cyc = 0;
        t = 0;
        while (!done && t < 150000) begin
            if (busy) busy_cyc++;
            if (inject && busy_cyc == 20) begin
                req_dst = 16'h0800; req_src = 16'h0000; req_len = 12'd40; req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        req_valid = 1'b0;
        check(done == 1'b1, "R5 done reached", done, 1);
        check(busy_cyc == cost, "R5 busy cycles", busy_cyc, cost);
        check(busy == 1'b0, "R5 busy low with done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", done, 0);
        check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R6 idle after run", {busy, done}, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            src_mem[i]   = 8'((i * 37 + 11) ^ (i >> 3));
            flash_mem[i] = 8'hFF;
        end
        for (int i = 0; i < 16; i++) src_mem[i * 7] = 8'hFF;
        for (int i = 0; i < 128; i++) src_mem[3072 + i] = 8'hFF;

        repeat (3) @(negedge clk);
        // R8
        check(busy == 0 && done == 0 && err == 0 && fl_prog == 0, "R8 reset state",
              {busy, done, err, fl_prog}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_req(16'h0100, 16'h0000, 128, 1'b0);   // R1 single full page
        run_req(16'h0400, 16'h0080, 300, 1'b0);   // R1 R2 three pages, padded
        run_req(16'h0203, 16'h0000, 64, 1'b0);    // R4 misaligned
        check(exp_q.size() == 0, "R4 nothing queued", exp_q.size(), 0);
        run_req(16'h0600, 16'h0C00, 128, 1'b0);   // R3 all-ones page
        run_req(16'h0A00, 16'h0010, 200, 1'b1);   // R6 inject while busy
        run_req(16'h0C00, 16'h0000, 0, 1'b0);     // R7 zero length
        run_req(16'h0E00, 16'h0005, 1, 1'b0);     // R2 single byte, rest filler
        check(flash_mem[12'h0E00] == src_mem[5], "R1 array holds byte",
              flash_mem[12'h0E00], src_mem[5]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule